// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block holds the error-capture state for one hardware unit. It keeps a 64-bit fault register and a mask for it, two action-select registers and a first-error register, all behind a single register access port. Every access moves one whole 64-bit word. The port carries a byte address, and the register index is that address shifted right by three. Hardware error lines set fault bits on any cycle. Software reads the bits and clears them.

The fault register and the mask register each have three write addresses. A plain write replaces the contents. An AND alias keeps only the bits that are one in the written word. An OR alias adds the bits that are one. Reading any of the three addresses returns the register they share.

The first-error register records the first group of unmasked faults that are newly set while it is empty, so software can tell which error came first. Any write to it empties it.

From the live unmasked faults the block drives an attention line and three classification lines. For each unmasked fault bit i, the pair {act0[i], act1[i]} gives its class:
- 00 is checkstop.
- 01 is recoverable.
- 10 and 11 are local.

Top module: `fault_capture_bank`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and attn, attn_checkstop, attn_recov, attn_local, unimpl_pulse and rd_valid are 0.
- R2: A write to index 0 replaces the whole fault register with the written word.
- R3: A write to index 1 sets fault to fault AND wdata. A write to index 2 sets fault to fault OR wdata. Reads of indices 0, 1 and 2 all return the fault register.
- R4: The mask register works the same way through its own three indices: 3 is a plain write, 4 is AND and 5 is OR. Reads of indices 3, 4 and 5 all return the mask.
- R5: Index 6 (act0) and index 7 (act1) are plain read/write registers.
- R6: Any write to index 8 (first-error) sets it to zero, whatever the written data.
- R7: hw_err bits are ORed into the fault register on every cycle. When a software write and an hw_err bit hit the same bit in the same cycle, the bit ends up set.
- R8: While the first-error register is zero and not being written, it captures the fault bits that become newly set in a cycle and are unmasked at that time. While it is nonzero, it holds its value until software clears it.
- R9: attn is 1 exactly when some bit has fault=1 and mask=0. For those bits, {act0,act1}=00 drives attn_checkstop, 01 drives attn_recov, and 1x drives attn_local.
- R10: A write to an index from 9 to 15 changes no register and raises unimpl_pulse for the next cycle only. A read of such an index returns zero.
- R11: A read access (acc_valid=1, acc_write=0) is answered in the following cycle with rd_valid=1, and rd_data holds the register value from before that cycle's update. rd_data is zero on cycles with no read answer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 7 | Byte address; register index is acc_addr[6:3] |
| acc_wdata | input | 64 | Write data |
| hw_err | input | 64 | Hardware error set lines |
| rd_valid | output | 1 | Read answer is valid |
| rd_data | output | 64 | Read answer data |
| attn | output | 1 | Some unmasked fault is set |
| attn_checkstop | output | 1 | An unmasked fault is classed checkstop |
| attn_recov | output | 1 | An unmasked fault is classed recoverable |
| attn_local | output | 1 | An unmasked fault is classed local |
| unimpl_pulse | output | 1 | A write to an unimplemented index occurred last cycle |

## Verification
The hardest case to reach is a software clear and a hardware set landing on the same fault bit in the same cycle. The next hardest is the first-error register having to ignore new faults once it holds a value. The stimulus aligns a plain zero write with an hw_err pulse in one cycle. It then builds a sequence of clear-first, set-one-bit, set-another-bit and reads the first-error register between the steps. A long pseudo-random phase follows, with sparse hardware errors and writes to random indices including the unimplemented ones. A behavioural model compares every output on every clock during this phase.

// File: rtl/fcb_pkg.sv
// Shared types for the fault capture bank: register indices and write-alias
// operations. Assumes 16 index slots (4 index bits above 3 byte-offset bits).
package fcb_pkg;
    localparam int IDX_W  = 4;
    localparam int ADDR_W = IDX_W + 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_FAULT     = 4'd0,
        IDX_FAULT_AND = 4'd1,
        IDX_FAULT_OR  = 4'd2,
        IDX_MASK      = 4'd3,
        IDX_MASK_AND  = 4'd4,
        IDX_MASK_OR   = 4'd5,
        IDX_ACT0      = 4'd6,
        IDX_ACT1      = 4'd7,
        IDX_FIRST     = 4'd8
    } reg_idx_e;

    localparam int LAST_IMPL = 8;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_PLAIN = 2'd1,
        OP_AND   = 2'd2,
        OP_OR    = 2'd3
    } alias_op_e;

    typedef struct packed {
        alias_op_e fault_op;
        alias_op_e mask_op;
        logic      act0_we;
        logic      act1_we;
        logic      first_clr;
        logic      unimpl_wr;
    } dec_t;
endpackage

// File: rtl/fcb_decode.sv
// Access decoder: turns a write request and register index into per-register
// alias operations. Purely combinational; assumes the caller gates by valid.
module fcb_decode
    import fcb_pkg::*;
(
    input  logic             wr,
    input  logic [IDX_W-1:0] idx,
    output dec_t             dec
);
    // Map an index to the operation it performs on its target register.
    always_comb begin
        dec = '{fault_op: OP_NONE, mask_op: OP_NONE, act0_we: 1'b0,
                act1_we: 1'b0, first_clr: 1'b0, unimpl_wr: 1'b0};
        if (wr) begin
            case (idx)
                IDX_FAULT:     dec.fault_op  = OP_PLAIN;
                IDX_FAULT_AND: dec.fault_op  = OP_AND;
                IDX_FAULT_OR:  dec.fault_op  = OP_OR;
                IDX_MASK:      dec.mask_op   = OP_PLAIN;
                IDX_MASK_AND:  dec.mask_op   = OP_AND;
                IDX_MASK_OR:   dec.mask_op   = OP_OR;
                IDX_ACT0:      dec.act0_we   = 1'b1;
                IDX_ACT1:      dec.act1_we   = 1'b1;
                IDX_FIRST:     dec.first_clr = 1'b1;
                default:       dec.unimpl_wr = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/fcb_alias_reg.sv
// One register reachable through plain, AND and OR write aliases, with an
// optional hardware set vector that wins over any software change per bit.
// Assumes op is OP_NONE when no write targets this register.
module fcb_alias_reg
    import fcb_pkg::*;
#(
    parameter int W = 64
) (
    input  logic      clk,
    input  logic      rst_n,
    input  alias_op_e op,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic [W-1:0] sw_val;

    // Resolve the software alias operation against the current value.
    always_comb begin
        case (op)
            OP_PLAIN: sw_val = wdata;
            OP_AND:   sw_val = q & wdata;
            OP_OR:    sw_val = q | wdata;
            default:  sw_val = q;
        endcase
        q_next = sw_val | hw_set;
    end

    // Store the next value; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q_next;
    end

    // Hardware set bits are present after the edge (R7).
    assert_hw_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hw_set) & ~q) == '0));
    // AND alias never sets a bit that was not already set or hardware-set (R3, R4).
    assert_and_only_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_AND) |=> ((q & ~$past(q) & ~$past(hw_set)) == '0));
    // OR alias never clears a bit (R3, R4).
    assert_or_only_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_OR) |=> (($past(q) & ~q) == '0));
endmodule

// File: rtl/fcb_first_err.sv
// First-error capture: while empty, latches fault bits that become set in a
// cycle and are unmasked; holds them until a software write empties it.
module fcb_first_err #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] fault_q,
    input  logic [W-1:0] fault_next,
    input  logic [W-1:0] mask_q,
    output logic [W-1:0] q
);
    logic [W-1:0] fresh;

    // Bits rising this cycle that the current mask lets through.
    assign fresh = fault_next & ~fault_q & ~mask_q;

    // Clear on write, else capture only while empty.
    always_ff @(posedge clk) begin
        if (!rst_n)           q <= '0;
        else if (clr)         q <= '0;
        else if (q == '0)     q <= fresh;
    end

    assert_clear_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
    assert_hold_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((q != '0) && !clr) |=> (q == $past(q)));
endmodule

// File: rtl/fcb_attn.sv
// Attention classifier: reduces unmasked fault bits into an attention flag and
// three class flags using per-bit codes {act0,act1}: 00 checkstop, 01
// recoverable, 1x local. Combinational.
module fcb_attn #(
    parameter int W = 64
) (
    input  logic [W-1:0] fault_q,
    input  logic [W-1:0] mask_q,
    input  logic [W-1:0] act0_q,
    input  logic [W-1:0] act1_q,
    output logic         attn,
    output logic         attn_checkstop,
    output logic         attn_recov,
    output logic         attn_local
);
    logic [W-1:0] live;
    logic [W-1:0] is_chk;
    logic [W-1:0] is_rec;
    logic [W-1:0] is_loc;

    // Classify each bit independently.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign live[i]   = fault_q[i] & ~mask_q[i];
        assign is_chk[i] = live[i] & ~act0_q[i] & ~act1_q[i];
        assign is_rec[i] = live[i] & ~act0_q[i] &  act1_q[i];
        assign is_loc[i] = live[i] &  act0_q[i];
    end

    // Reduce to the summary flags.
    always_comb begin
        attn           = |live;
        attn_checkstop = |is_chk;
        attn_recov     = |is_rec;
        attn_local     = |is_loc;
    end
endmodule

// File: rtl/fault_capture_bank.sv
// Fault capture bank top: register access port, fault/mask alias registers,
// action-select storage, first-error capture and attention outputs.
// Assumes 64-bit whole-word accesses; low three address bits are ignored.
module fault_capture_bank
    import fcb_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] hw_err,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              attn,
    output logic              attn_checkstop,
    output logic              attn_recov,
    output logic              attn_local,
    output logic              unimpl_pulse
);
    logic [IDX_W-1:0]  idx;
    dec_t              dec;
    logic [DATA_W-1:0] fault_q, fault_next, mask_q, mask_next;
    logic [DATA_W-1:0] act0_q, act1_q, first_q;
    logic [DATA_W-1:0] rd_mux;

    assign idx = acc_addr[ADDR_W-1:3];

    fcb_decode u_dec (
        .wr  (acc_valid & acc_write),
        .idx (idx),
        .dec (dec)
    );

    fcb_alias_reg #(.W(DATA_W)) u_fault (
        .clk (clk), .rst_n (rst_n), .op (dec.fault_op), .wdata (acc_wdata),
        .hw_set (hw_err), .q (fault_q), .q_next (fault_next)
    );

    fcb_alias_reg #(.W(DATA_W)) u_mask (
        .clk (clk), .rst_n (rst_n), .op (dec.mask_op), .wdata (acc_wdata),
        .hw_set ('0), .q (mask_q), .q_next (mask_next)
    );

    fcb_first_err #(.W(DATA_W)) u_first (
        .clk (clk), .rst_n (rst_n), .clr (dec.first_clr),
        .fault_q (fault_q), .fault_next (fault_next), .mask_q (mask_q),
        .q (first_q)
    );

    fcb_attn #(.W(DATA_W)) u_attn (
        .fault_q (fault_q), .mask_q (mask_q), .act0_q (act0_q), .act1_q (act1_q),
        .attn (attn), .attn_checkstop (attn_checkstop),
        .attn_recov (attn_recov), .attn_local (attn_local)
    );

    // Action-select registers: plain storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act0_q <= '0;
            act1_q <= '0;
        end else begin
            if (dec.act0_we) act0_q <= acc_wdata;
            if (dec.act1_we) act1_q <= acc_wdata;
        end
    end

    // Read selection: aliases return their target, unimplemented returns zero.
    always_comb begin
        case (idx)
            IDX_FAULT, IDX_FAULT_AND, IDX_FAULT_OR: rd_mux = fault_q;
            IDX_MASK, IDX_MASK_AND, IDX_MASK_OR:    rd_mux = mask_q;
            IDX_ACT0:                               rd_mux = act0_q;
            IDX_ACT1:                               rd_mux = act1_q;
            IDX_FIRST:                              rd_mux = first_q;
            default:                                rd_mux = '0;
        endcase
    end

    // Registered read answer and unimplemented-write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid     <= 1'b0;
            rd_data      <= '0;
            unimpl_pulse <= 1'b0;
        end else begin
            rd_valid     <= acc_valid & ~acc_write;
            rd_data      <= (acc_valid & ~acc_write) ? rd_mux : '0;
            unimpl_pulse <= dec.unimpl_wr;
        end
    end

    assert_unimpl_write_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (idx > IDX_W'(LAST_IMPL))) |=> unimpl_pulse);
    assert_unimpl_from_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_pulse |-> $past(acc_valid && acc_write));
    assert_unimpl_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (idx > IDX_W'(LAST_IMPL)) && (hw_err == '0))
        |=> ($stable(fault_q) && $stable(mask_q) && $stable(act0_q) && $stable(act1_q)));
    assert_read_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && !acc_write));
    assert_attn_classified_R9: assert property (@(posedge clk) disable iff (!rst_n)
        attn == (attn_checkstop | attn_recov | attn_local));
endmodule

// File: tb/fault_capture_bank_tb_top.sv
`timescale 1ns/100ps
module fault_capture_bank_tb_top;
    localparam int W = 64;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [6:0] acc_addr = '0;
    logic [W-1:0] acc_wdata = '0, hw_err = '0;
    logic rd_valid, attn, attn_checkstop, attn_recov, attn_local, unimpl_pulse;
    logic [W-1:0] rd_data;

    int checks = 0, fails = 0, cycles = 0;
    bit model_on = 1'b0;

    // reference model state
    logic [W-1:0] m_fault = '0, m_mask = '0, m_a0 = '0, m_a1 = '0, m_first = '0;
    logic [W-1:0] m_rdata = '0;
    logic m_rvalid = 1'b0, m_unimpl = 1'b0;

    always #2.5 clk = ~clk;

    fault_capture_bank dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .hw_err(hw_err),
        .rd_valid(rd_valid), .rd_data(rd_data), .attn(attn),
        .attn_checkstop(attn_checkstop), .attn_recov(attn_recov),
        .attn_local(attn_local), .unimpl_pulse(unimpl_pulse)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] model_read(input int i);
        case (i)
            0, 1, 2: return m_fault;
            3, 4, 5: return m_mask;
            6:       return m_a0;
            7:       return m_a1;
            8:       return m_first;
            default: return '0;
        endcase
    endfunction

    // behavioural reference, updated at each edge from the sampled inputs
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fault = '0; m_mask = '0; m_a0 = '0; m_a1 = '0; m_first = '0;
            m_rdata = '0; m_rvalid = 1'b0; m_unimpl = 1'b0;
        end else begin
            int i;
            logic wr, rd;
            logic [W-1:0] nf, nm, fresh;
            i  = int'(acc_addr[6:3]);
            wr = acc_valid && acc_write;
            rd = acc_valid && !acc_write;
            m_rvalid = rd;
            m_rdata  = rd ? model_read(i) : '0;
            m_unimpl = wr && (i >= 9);
            nf = m_fault; nm = m_mask;
            if (wr) begin
                if (i == 0) nf = acc_wdata;
                if (i == 1) nf = m_fault & acc_wdata;
                if (i == 2) nf = m_fault | acc_wdata;
                if (i == 3) nm = acc_wdata;
                if (i == 4) nm = m_mask & acc_wdata;
                if (i == 5) nm = m_mask | acc_wdata;
                if (i == 6) m_a0 = acc_wdata;
                if (i == 7) m_a1 = acc_wdata;
            end
            nf = nf | hw_err;
            fresh = nf & ~m_fault & ~m_mask;
            if (wr && i == 8) m_first = '0;
            else if (m_first == '0) m_first = fresh;
            m_fault = nf; m_mask = nm;
        end
    end

    // compare every output against the model on every clock
    always @(negedge clk) begin
        if (model_on) begin
            logic [W-1:0] live;
            live = m_fault & ~m_mask;
            check("R11 rd_valid", W'(rd_valid), W'(m_rvalid));
            check("R11 rd_data", rd_data, m_rdata);
            check("R10 unimpl_pulse", W'(unimpl_pulse), W'(m_unimpl));
            check("R9 attn", W'(attn), W'(|live));
            check("R9 checkstop", W'(attn_checkstop), W'(|(live & ~m_a0 & ~m_a1)));
            check("R9 recov", W'(attn_recov), W'(|(live & ~m_a0 & m_a1)));
            check("R9 local", W'(attn_local), W'(|(live & m_a0)));
        end
    end

    task automatic wr_reg(input int i, input logic [W-1:0] d);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 7'(i << 3); acc_wdata = d;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd_check(input string tag, input int i, input logic [W-1:0] exp);
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 7'((i << 3) | 5);
        @(posedge clk); #1;
        acc_valid = 1'b0;
        @(negedge clk);
        check({tag, " rd_valid"}, W'(rd_valid), W'(1));
        check(tag, rd_data, exp);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    localparam logic [W-1:0] PA = 64'hF0F0_1234_5678_00FF;
    localparam logic [W-1:0] PB = 64'h0FF0_FFFF_0000_FF0F;
    localparam logic [W-1:0] PC = 64'h0000_0000_8000_0001;

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 attn", W'(attn), '0);
        check("R1 unimpl", W'(unimpl_pulse), '0);
        check("R1 rd_valid", W'(rd_valid), '0);
        for (int i = 0; i <= 8; i++) rd_check("R1 reg zero", i, '0);
        model_on = 1'b1;
        // R2 plain write
        wr_reg(3, '1);  // mask all so first-error stays out of the way here
        wr_reg(0, PA);
        rd_check("R2 plain fault", 0, PA);
        // R3 aliases
        wr_reg(1, PB);
        rd_check("R3 and alias", 2, PA & PB);
        wr_reg(2, PC);
        rd_check("R3 or alias", 1, (PA & PB) | PC);
        // R4 mask aliases
        wr_reg(3, PA);
        rd_check("R4 mask plain", 3, PA);
        wr_reg(4, PB);
        rd_check("R4 mask and", 5, PA & PB);
        wr_reg(5, PC);
        rd_check("R4 mask or", 4, (PA & PB) | PC);
        // R5 action registers
        wr_reg(6, PB);
        wr_reg(7, PC);
        rd_check("R5 act0", 6, PB);
        rd_check("R5 act1", 7, PC);
        // R6 clear first-error with arbitrary data
        wr_reg(8, '1);
        rd_check("R6 first cleared", 8, '0);
        // R8 capture first group, then hold
        wr_reg(3, '0);
        wr_reg(0, '0);
        wr_reg(8, 64'h5);
        wr_reg(2, 64'h8);
        wr_reg(2, 64'h80);
        rd_check("R8 first holds bit3", 8, 64'h8);
        rd_check("R8 fault has both", 0, 64'h88);
        // R7 hardware set beats same-cycle clear
        @(posedge clk); #1;
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 7'd0; acc_wdata = '0;
        hw_err = 64'h200;
        @(posedge clk); #1;
        acc_valid = 1'b0; acc_write = 1'b0; hw_err = '0;
        rd_check("R7 hw wins", 0, 64'h200);
        // R9 classification of bit 1
        wr_reg(0, '0); wr_reg(6, '0); wr_reg(7, '0);
        wr_reg(2, 64'h2);
        @(negedge clk);
        check("R9 checkstop", {attn, attn_checkstop, attn_recov, attn_local}, 64'b1100);
        wr_reg(7, 64'h2);
        @(negedge clk);
        check("R9 recov", {attn, attn_checkstop, attn_recov, attn_local}, 64'b1010);
        wr_reg(6, 64'h2);
        @(negedge clk);
        check("R9 local", {attn, attn_checkstop, attn_recov, attn_local}, 64'b1001);
        wr_reg(5, 64'h2);
        @(negedge clk);
        check("R9 masked", {attn, attn_checkstop, attn_recov, attn_local}, 64'b0000);
        // R10 unimplemented index
        wr_reg(9, '1);
        @(negedge clk);
        check("R10 pulse high", W'(unimpl_pulse), 64'h1);
        @(negedge clk);
        check("R10 pulse low", W'(unimpl_pulse), 64'h0);
        rd_check("R10 read zero", 9, '0);
        rd_check("R10 fault untouched", 0, 64'h2);
        rd_check("R10 act0 untouched", 6, 64'h2);
        // random phase, model compared every clock
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            acc_valid = ($urandom % 3) != 0;
            acc_write = $urandom % 2;
            acc_addr  = 7'($urandom);
            acc_wdata = {$urandom, $urandom};
            hw_err    = (($urandom % 6) == 0) ? (64'h1 << ($urandom % 64)) : '0;
        end
        @(posedge clk); #1;
        acc_valid = 1'b0; hw_err = '0;
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule